// File: doc/BRIEF.md
# Sandbox Region Permission Checker

This block decides, on every cycle, whether the core is running confined sandbox code. It then polices what that code does. Four region descriptors and one handler-address register come in as plain vectors. Each region descriptor carries a valid bit, execute/write/read permissions and a naturally aligned power-of-two (NAPOT) size and base. The core is in sandbox mode when its fetch PC falls inside a valid region that grants execute. Code outside every such region is the main application and is never checked.

While in sandbox mode, the block checks several things. A taken branch or jump target must land in an executable region. A sequential next PC must stay inside the region that holds the current PC. Loads need a readable region and stores need a writable one. ECALL, EBREAK and CSR instructions are forbidden. Any failure raises a redirect to the handler address, which leaves sandbox mode. The redirect is not a trap cause. A per-region error vector shows which region matched the failing address but lacked the permission. A page or access fault from elsewhere in the pipeline is passed on only when no redirect claims the same instruction.

All outputs are registered and appear one clock after the inputs they describe.

Top module: `sbx_guard`

## Requirements
- R1: Region descriptor layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute. The size field starts at bit 11 as RS consecutive ones followed by a zero. The region is the 2^(RS+12)-byte block whose address bits at and above 12+RS equal the descriptor's; addresses outside it do not match.
- R2: One cycle after a PC inside a valid region with execute permission, sbx_mode_o is 1. A PC in a region without execute permission, or in no region, gives 0.
- R3: When every region valid bit is clear, sbx_mode_o and redir_o stay 0, and fault_o follows pgfault_i.
- R4: In sandbox mode with flow_i = 2 (taken branch/jump), a next_pc_i not inside a valid execute region raises redir_o.
- R5: In sandbox mode with mem_op_i = 1 (load), a mem_addr_i not inside a valid readable region raises redir_o. A readable match raises none.
- R6: In sandbox mode with mem_op_i = 2 (store), a mem_addr_i not inside a valid writable region raises redir_o. A writable match raises none.
- R7: In sandbox mode, instr_priv_i = 1 (ECALL, EBREAK, CSR access) raises redir_o. Outside sandbox mode no input raises redir_o.
- R8: In sandbox mode with flow_i = 1 (sequential), a next_pc_i outside the region holding pc_i raises redir_o. A next_pc_i inside it raises none.
- R9: With redir_o = 1, redir_addr_o equals the handler register with bits 1:0 forced to zero.
- R10: fault_o is pgfault_i registered, suppressed whenever redir_o is raised for the same instruction.
- R11: With redir_o = 1, err_region_o bit i is set when region i matched an address whose jump, load or store check failed. err_region_o is 0 when no redirect occurs.
- R12: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| region_cfg_i | input | NREG*XLEN | Region descriptors, region i at bits [i*XLEN +: XLEN] |
| trap_cfg_i | input | XLEN | Handler address register |
| pc_i | input | XLEN | Current fetch PC |
| flow_i | input | 2 | 0 none, 1 sequential, 2 taken branch/jump |
| next_pc_i | input | XLEN | Next PC or control-transfer target |
| mem_op_i | input | 2 | 0 none, 1 load, 2 store |
| mem_addr_i | input | XLEN | Load/store effective address |
| instr_priv_i | input | 1 | Instruction is ECALL, EBREAK or CSR access |
| pgfault_i | input | 1 | Page or access fault reported for this instruction |
| sbx_mode_o | output | 1 | Instruction ran in sandbox mode |
| redir_o | output | 1 | Redirect to handler requested |
| redir_addr_o | output | XLEN | Handler address, 4-byte aligned, 0 when no redirect |
| fault_o | output | 1 | Fault allowed through (no redirect) |
| err_region_o | output | NREG | Regions that matched a failing access |

## Verification
A wrong size decode shows as a region boundary that sits one power of two off. To catch it, the vectors probe addresses just inside and just outside regions of 4 KiB, 8 KiB, 64 KiB and 1 MiB. A wrong mode decision or a wrong permission select shows on sbx_mode_o, redir_o or err_region_o one clock after the offending inputs. Every vector is therefore compared on the cycle after it is driven. Priority slips show as fault_o and redir_o being high together. Leaks from the main application show as a redirect outside sandbox mode. Both are watched on every cycle.

// File: rtl/sbx_guard_pkg.sv
package sbx_guard_pkg;
  typedef enum logic [1:0] {
    FLOW_NONE = 2'd0,
    FLOW_SEQ  = 2'd1,
    FLOW_JUMP = 2'd2
  } flow_e;

  typedef enum logic [1:0] {
    MEM_NONE  = 2'd0,
    MEM_LOAD  = 2'd1,
    MEM_STORE = 2'd2
  } mem_e;

  localparam int unsigned V_BIT  = 0;
  localparam int unsigned R_BIT  = 1;
  localparam int unsigned W_BIT  = 2;
  localparam int unsigned X_BIT  = 3;
  localparam int unsigned SZ_LSB = 11;
  localparam int unsigned PAGE_W = 12;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
    logic v;
  } perm_t;
endpackage

// File: rtl/sbx_region_match.sv
module sbx_region_match
  import sbx_guard_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned RS_MAX = 20,
  parameter int unsigned NADDR  = 3
) (
  input  logic [XLEN-1:0]             cfg_i,
  input  logic [NADDR-1:0][XLEN-1:0]  addr_i,
  output logic [NADDR-1:0]            hit_o,
  output perm_t                       perm_o
);
  localparam int unsigned FW = XLEN - SZ_LSB;

  logic [FW-1:0]   field;
  logic [FW-1:0]   run;
  logic [XLEN-1:0] care;

  assign field = cfg_i[XLEN-1:SZ_LSB];
  // ones at field bits 0..RS: trailing ones plus the terminating zero
  assign run   = field ^ (field + 1'b1);

  for (genvar a = 0; a < XLEN; a++) begin : g_care
    if (a < PAGE_W) begin : g_low
      assign care[a] = 1'b0;
    end else if (a >= PAGE_W + RS_MAX) begin : g_cap
      assign care[a] = 1'b1;
    end else begin : g_napot
      assign care[a] = ~run[a-SZ_LSB];
    end
  end

  for (genvar k = 0; k < NADDR; k++) begin : g_hit
    assign hit_o[k] = cfg_i[V_BIT] && (((addr_i[k] ^ cfg_i) & care) == '0);
  end

  assign perm_o = '{x: cfg_i[X_BIT], w: cfg_i[W_BIT], r: cfg_i[R_BIT], v: cfg_i[V_BIT]};
endmodule

// File: rtl/sbx_verdict.sv
module sbx_verdict
  import sbx_guard_pkg::*;
#(
  parameter int unsigned NREG = 4
) (
  input  logic [NREG-1:0] pc_hit_i,
  input  logic [NREG-1:0] tgt_hit_i,
  input  logic [NREG-1:0] mem_hit_i,
  input  logic [NREG-1:0] xm_i,
  input  logic [NREG-1:0] rm_i,
  input  logic [NREG-1:0] wm_i,
  input  flow_e           flow_i,
  input  mem_e            mem_i,
  input  logic            priv_i,
  input  logic            pgf_i,
  output logic            sbx_o,
  output logic            redir_o,
  output logic            fault_o,
  output logic [NREG-1:0] err_o
);
  logic [NREG-1:0] pc_exec;
  logic jump_bad, seq_bad, ld_bad, st_bad;

  always_comb begin
    pc_exec  = pc_hit_i & xm_i;
    sbx_o    = |pc_exec;
    jump_bad = (flow_i == FLOW_JUMP) && !(|(tgt_hit_i & xm_i));
    seq_bad  = (flow_i == FLOW_SEQ) && ((pc_exec & ~tgt_hit_i) != '0);
    ld_bad   = (mem_i == MEM_LOAD)  && !(|(mem_hit_i & rm_i));
    st_bad   = (mem_i == MEM_STORE) && !(|(mem_hit_i & wm_i));
    redir_o  = sbx_o && (priv_i || jump_bad || seq_bad || ld_bad || st_bad);
    fault_o  = pgf_i && !redir_o;
    err_o    = '0;
    if (redir_o) begin
      if (jump_bad) err_o = err_o | (tgt_hit_i & ~xm_i);
      if (ld_bad)   err_o = err_o | (mem_hit_i & ~rm_i);
      if (st_bad)   err_o = err_o | (mem_hit_i & ~wm_i);
    end
  end
endmodule

// File: rtl/sbx_guard.sv
module sbx_guard
  import sbx_guard_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NREG   = 4,
  parameter int unsigned RS_MAX = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NREG*XLEN-1:0] region_cfg_i,
  input  logic [XLEN-1:0]      trap_cfg_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [1:0]           flow_i,
  input  logic [XLEN-1:0]      next_pc_i,
  input  logic [1:0]           mem_op_i,
  input  logic [XLEN-1:0]      mem_addr_i,
  input  logic                 instr_priv_i,
  input  logic                 pgfault_i,
  output logic                 sbx_mode_o,
  output logic                 redir_o,
  output logic [XLEN-1:0]      redir_addr_o,
  output logic                 fault_o,
  output logic [NREG-1:0]      err_region_o
);
  localparam int unsigned NADDR = 3;
  localparam int unsigned A_PC  = 0;
  localparam int unsigned A_TGT = 1;
  localparam int unsigned A_MEM = 2;

  logic [NADDR-1:0][XLEN-1:0] addrs;
  logic [NREG-1:0] pc_hit, tgt_hit, mem_hit, xm, rm, wm;
  logic            sbx_d, redir_d, fault_d;
  logic [NREG-1:0] err_d;

  assign addrs[A_PC]  = pc_i;
  assign addrs[A_TGT] = next_pc_i;
  assign addrs[A_MEM] = mem_addr_i;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [NADDR-1:0] hit;
    perm_t            perm;

    sbx_region_match #(
      .XLEN  (XLEN),
      .RS_MAX(RS_MAX),
      .NADDR (NADDR)
    ) u_match (
      .cfg_i (region_cfg_i[i*XLEN +: XLEN]),
      .addr_i(addrs),
      .hit_o (hit),
      .perm_o(perm)
    );

    assign pc_hit[i]  = hit[A_PC];
    assign tgt_hit[i] = hit[A_TGT];
    assign mem_hit[i] = hit[A_MEM];
    assign xm[i]      = perm.x;
    assign rm[i]      = perm.r;
    assign wm[i]      = perm.w;
  end

  sbx_verdict #(.NREG(NREG)) u_verdict (
    .pc_hit_i (pc_hit),
    .tgt_hit_i(tgt_hit),
    .mem_hit_i(mem_hit),
    .xm_i     (xm),
    .rm_i     (rm),
    .wm_i     (wm),
    .flow_i   (flow_e'(flow_i)),
    .mem_i    (mem_e'(mem_op_i)),
    .priv_i   (instr_priv_i),
    .pgf_i    (pgfault_i),
    .sbx_o    (sbx_d),
    .redir_o  (redir_d),
    .fault_o  (fault_d),
    .err_o    (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbx_mode_o   <= 1'b0;
      redir_o      <= 1'b0;
      redir_addr_o <= '0;
      fault_o      <= 1'b0;
      err_region_o <= '0;
    end else begin
      sbx_mode_o   <= sbx_d;
      redir_o      <= redir_d;
      redir_addr_o <= redir_d ? {trap_cfg_i[XLEN-1:2], 2'b00} : '0;
      fault_o      <= fault_d;
      err_region_o <= err_d;
    end
  end
endmodule

// File: rtl/sbx_guard_chk.sv
module sbx_guard_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NREG*XLEN-1:0] region_cfg_i,
  input logic                 instr_priv_i,
  input logic                 sbx_mode_o,
  input logic                 redir_o,
  input logic [XLEN-1:0]      redir_addr_o,
  input logic                 fault_o,
  input logic [NREG-1:0]      err_region_o
);
  logic [NREG-1:0] vld;
  always_comb begin
    for (int i = 0; i < NREG; i++) vld[i] = region_cfg_i[i*XLEN];
  end

  AST_REDIR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> redir_addr_o[1:0] == 2'b00); // R9

  AST_REDIR_ONLY_SBX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> sbx_mode_o); // R7

  AST_FAULT_YIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> !fault_o); // R10

  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redir_o |-> err_region_o == '0); // R11

  AST_PRIV_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbx_mode_o && $past(instr_priv_i) && $past(rst_ni)) |-> redir_o); // R7

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(vld) == '0 && $past(rst_ni)) |-> (!sbx_mode_o && !redir_o)); // R3
endmodule

bind sbx_guard sbx_guard_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .region_cfg_i(region_cfg_i),
  .instr_priv_i(instr_priv_i),
  .sbx_mode_o  (sbx_mode_o),
  .redir_o     (redir_o),
  .redir_addr_o(redir_addr_o),
  .fault_o     (fault_o),
  .err_region_o(err_region_o)
);

// File: tb/sbx_guard_tb.sv
module sbx_guard_tb;
  localparam int XLEN = 64;
  localparam int NREG = 4;
  localparam time TCK = 4ns;

  // code 64 KiB X+R, heap 1 MiB R+W, stack 4 KiB R, library 8 KiB X
  localparam logic [XLEN-1:0] CFG0 = 64'h0000_0000_1000_780B;
  localparam logic [XLEN-1:0] CFG1 = 64'h0000_0000_2007_F807;
  localparam logic [XLEN-1:0] CFG2 = 64'h0000_0000_3000_0003;
  localparam logic [XLEN-1:0] CFG3 = 64'h0000_0000_4000_0809;
  localparam logic [XLEN-1:0] TRAP = 64'h0000_0000_5000_0003;
  localparam logic [XLEN-1:0] TRAP_AL = 64'h0000_0000_5000_0000;

  typedef struct packed {
    logic [7:0]  req;
    logic [63:0] pc;
    logic [1:0]  flow;
    logic [63:0] nxt;
    logic [1:0]  mem;
    logic [63:0] maddr;
    logic        priv;
    logic        pgf;
    logic        e_sbx;
    logic        e_redir;
    logic        e_fault;
    logic [3:0]  e_err;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  64'h1000_0100, 2'd1, 64'h1000_0104, 2'd0, 64'h0,          1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000}, // R2
    '{8'd4,  64'h1000_0100, 2'd2, 64'h4000_0010, 2'd0, 64'h0,          1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000}, // R4 ok
    '{8'd4,  64'h1000_0100, 2'd2, 64'h2000_0000, 2'd0, 64'h0,          1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0010}, // R4 R11
    '{8'd4,  64'h1000_0100, 2'd2, 64'h6000_0000, 2'd0, 64'h0,          1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000}, // R4
    '{8'd5,  64'h1000_0100, 2'd0, 64'h0,         2'd1, 64'h200F_FFF8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000}, // R5 R1
    '{8'd5,  64'h1000_0100, 2'd0, 64'h0,         2'd1, 64'h2010_0000,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000}, // R5 R1
    '{8'd6,  64'h1000_0100, 2'd0, 64'h0,         2'd2, 64'h3000_0010,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0100}, // R6 R11
    '{8'd6,  64'h1000_0100, 2'd0, 64'h0,         2'd2, 64'h2000_0010,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000}, // R6
    '{8'd5,  64'h1000_0100, 2'd0, 64'h0,         2'd1, 64'h1000_0200,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000}, // R5
    '{8'd6,  64'h1000_0100, 2'd0, 64'h0,         2'd2, 64'h1000_0200,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0001}, // R6 R11
    '{8'd7,  64'h1000_0100, 2'd0, 64'h0,         2'd0, 64'h0,          1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000}, // R7
    '{8'd8,  64'h1000_0100, 2'd1, 64'h1001_0000, 2'd0, 64'h0,          1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000}, // R8
    '{8'd8,  64'h1000_0100, 2'd1, 64'h1000_FFFC, 2'd0, 64'h0,          1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000}, // R8
    '{8'd7,  64'h8000_0000, 2'd2, 64'h6000_0000, 2'd2, 64'h3000_0010,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R7 R10
    '{8'd10, 64'h1000_0100, 2'd0, 64'h0,         2'd2, 64'h3000_0010,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0100}, // R10
    '{8'd10, 64'h1000_0100, 2'd0, 64'h0,         2'd1, 64'h2000_0000,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0000}, // R10
    '{8'd8,  64'h4000_1FF0, 2'd1, 64'h4000_2000, 2'd0, 64'h0,          1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000}, // R8 R1
    '{8'd2,  64'h4000_2000, 2'd0, 64'h0,         2'd0, 64'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}, // R2 R1
    '{8'd2,  64'h3000_0010, 2'd0, 64'h0,         2'd0, 64'h0,          1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}, // R2 R7
    '{8'd2,  64'h0FFF_FFFC, 2'd0, 64'h0,         2'd0, 64'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}  // R2 R1
  };

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [NREG*XLEN-1:0] region_cfg_i;
  logic [XLEN-1:0]      trap_cfg_i, pc_i, next_pc_i, mem_addr_i;
  logic [1:0]           flow_i, mem_op_i;
  logic                 instr_priv_i, pgfault_i;
  logic                 sbx_mode_o, redir_o, fault_o;
  logic [XLEN-1:0]      redir_addr_o;
  logic [NREG-1:0]      err_region_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(TCK/2) clk_i = ~clk_i;

  sbx_guard u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pc_i = v.pc; flow_i = v.flow; next_pc_i = v.nxt;
    mem_op_i = v.mem; mem_addr_i = v.maddr;
    instr_priv_i = v.priv; pgfault_i = v.pgf;
  endtask

  task automatic expect_out(input string req, input vec_t v);
    chk({req, " sbx"},   {63'd0, sbx_mode_o}, {63'd0, v.e_sbx});
    chk({req, " redir"}, {63'd0, redir_o},    {63'd0, v.e_redir});
    chk({req, " fault"}, {63'd0, fault_o},    {63'd0, v.e_fault});
    chk({req, " err"},   {60'd0, err_region_o}, {60'd0, v.e_err});
    chk("R9 addr", redir_addr_o, v.e_redir ? TRAP_AL : 64'd0);
  endtask

  initial begin
    #(TCK*100000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    region_cfg_i = {CFG3, CFG2, CFG1, CFG0};
    trap_cfg_i   = TRAP;
    drive(VECS[10]);
    repeat (3) @(negedge clk_i);
    // R12: outputs held low during reset despite a violating input
    chk("R12 sbx",   {63'd0, sbx_mode_o}, 64'd0);
    chk("R12 redir", {63'd0, redir_o},    64'd0);
    chk("R12 addr",  redir_addr_o,        64'd0);
    chk("R12 err",   {60'd0, err_region_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      @(negedge clk_i);
      expect_out($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i]);
    end

    // R3: valid bits cleared, other descriptor bits untouched
    @(negedge clk_i);
    region_cfg_i = {CFG3, CFG2, CFG1, CFG0} & ~{{63'd0, 1'b1}, {63'd0, 1'b1}, {63'd0, 1'b1}, {63'd0, 1'b1}};
    drive('{8'd3, 64'h1000_0100, 2'd2, 64'h6000_0000, 2'd2, 64'h3000_0010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000});
    @(negedge clk_i);
    chk("R3 sbx",   {63'd0, sbx_mode_o}, 64'd0);
    chk("R3 redir", {63'd0, redir_o},    64'd0);
    chk("R3 fault", {63'd0, fault_o},    64'd1);

    // R1: re-enable only the code region, probe its last and first-outside byte
    region_cfg_i = {CFG3 & ~64'd1, CFG2 & ~64'd1, CFG1 & ~64'd1, CFG0};
    drive('{8'd1, 64'h1000_FFFC, 2'd0, 64'h0, 2'd0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000});
    @(negedge clk_i);
    chk("R1 top-of-region", {63'd0, sbx_mode_o}, 64'd1);
    pc_i = 64'h1001_0000;
    @(negedge clk_i);
    chk("R1 past-region", {63'd0, sbx_mode_o}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule